// File: doc/BRIEF.md
# Multi-Channel Window Alert with Hysteresis

This block sits behind a converter that produces a stream of 12-bit results, each tagged with a 3-bit channel number covering eight channels. Channel numbers 0 to 3 each have a window: an upper limit, a lower limit and a hysteresis count. A result above the upper limit or below the lower limit sets a sticky alert for that channel and side. The alert stays set until a later result for the same channel comes back inside the limit by at least the hysteresis count, or until the host issues a clear command. Channel numbers 4 to 7 pass through with no window.

Every accepted result comes back one clock later as a 16-bit word. The word holds a global alert flag, the channel number and the raw result. The alert output is the registered OR of all per-channel alert bits. A byte-wide register port lets the host write and read the twelve window registers, read the per-channel alert status and issue the clear command.

Top module: `win_alert_top`

## Requirements
- R1: After reset, every upper limit reads 0xFFF, every lower limit and hysteresis count reads 0, all alert status is 0, `alert_o` is 0 and `out_valid` is 0.
- R2: A result for channel number 4, 5, 6 or 7 never sets or clears any alert status and never changes `alert_o`.
- R3: For channels 0 to 3, a result strictly greater than the channel's upper limit sets its upper alert, and a result strictly less than its lower limit sets its lower alert. A result equal to a limit sets nothing.
- R4: A set upper alert clears when a result for that channel is less than or equal to (upper limit − hysteresis). A set lower alert clears when a result is greater than or equal to (lower limit + hysteresis).
- R5: A result that lies between a limit and that limit's release point leaves the alert state unchanged.
- R6: The release points saturate. Upper − hysteresis stops at 0 and lower + hysteresis stops at 0xFFF, with no wraparound.
- R7: One clock after `res_valid`, `out_valid` is 1 and `out_word` is {flag, channel[2:0], result[11:0]}, with the flag in bit 15. The flag is 1 when any alert status bit, including the one just updated, is set.
- R8: A write to address 13 with data bit 0 set clears all alert status and `alert_o` at the next clock. It overrides a result strobe in the same cycle, so that result's flag is 0.
- R9: Register map: address 0+i is the upper limit of channel i, 4+i the lower limit, and 8+i the hysteresis (i = 0 to 3). With `reg_byte_sel`=0 the access covers the high byte: bits 3:0 are register bits 11:8 and bits 7:4 read 0. With `reg_byte_sel`=1 it covers bits 7:0. A byte write changes only its own byte.
- R10: Address 12, low byte, is the read-only status. Bit i is the upper alert and bit 4+i the lower alert of channel i. Writes to address 12 have no effect.
- R11: `alert_o` is a register that follows the OR of all status bits, one clock after a strobe or a clear. With no strobe and no clear, no status or output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Result strobe |
| res_ch | input | 3 | Channel number of the result |
| res_data | input | 12 | Conversion result, straight binary |
| reg_wr | input | 1 | Register byte write strobe |
| reg_addr | input | 4 | Register address |
| reg_byte_sel | input | 1 | 0 = high byte, 1 = low byte |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte (combinational on address and byte select) |
| out_valid | output | 1 | Result word valid |
| out_word | output | 16 | Flag, channel and result |
| alert_o | output | 1 | Active-high alert |

## Verification
On every cycle, the assertions check the following:
- A result past a limit sets that channel's status.
- A clear empties all status.
- A cycle with no strobe and no clear leaves the status untouched.
- A result on a window-less channel leaves the alert unchanged.
- The word's flag matches the alert output.
- The high byte read always has zero padding.

The scoreboard scenarios show what needs a sequence of results: release only past the hysteresis band, hold inside that band, saturation at both ends of the scale, a flag raised by a different channel, and a clear that collides with a strobe.

// File: rtl/win_alert_pkg.sv
package win_alert_pkg;

   // Register-window kinds, in address order
   typedef enum logic [1:0] {
      KIND_UPPER = 2'd0,
      KIND_LOWER = 2'd1,
      KIND_HYST  = 2'd2,
      KIND_CTRL  = 2'd3
   } reg_kind_e;

   // Bit 0 of a write to the clear address triggers the clear
   localparam int unsigned CLR_BIT = 0;

endpackage

// File: rtl/win_lim_regs.sv
module win_lim_regs
   import win_alert_pkg::*;
#(
   parameter int unsigned NUM_LIM = 4,
   parameter int unsigned RES_W   = 12,
   parameter int unsigned ADDR_W  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 byte_sel,
   input  logic [7:0]           wdata,
   input  logic [2*NUM_LIM-1:0] stat_bits,
   output logic [7:0]           rdata,
   output logic [RES_W-1:0]     up_o [NUM_LIM],
   output logic [RES_W-1:0]     lo_o [NUM_LIM],
   output logic [RES_W-1:0]     hy_o [NUM_LIM],
   output logic                 clr_o
);
   localparam int unsigned HI_BITS = RES_W - 8;
   localparam int unsigned LO_BASE = NUM_LIM;
   localparam int unsigned HY_BASE = 2 * NUM_LIM;
   localparam int unsigned ST_ADDR = 3 * NUM_LIM;
   localparam int unsigned CL_ADDR = 3 * NUM_LIM + 1;

   generate
      if (RES_W < 9 || RES_W > 16) begin : g_bad_w
         $error("win_lim_regs: RES_W must be 9..16");
      end
      if (CL_ADDR >= (1 << ADDR_W)) begin : g_bad_a
         $error("win_lim_regs: ADDR_W too small for map");
      end
      if (2 * NUM_LIM > 8) begin : g_bad_s
         $error("win_lim_regs: status must fit one byte");
      end
   endgenerate

   function automatic logic [RES_W-1:0] merge_byte(input logic [RES_W-1:0] old,
                                                    input logic sel,
                                                    input logic [7:0] b);
      logic [RES_W-1:0] v;
      v = old;
      if (sel) v[7:0] = b;
      else     v[RES_W-1:8] = b[HI_BITS-1:0];
      return v;
   endfunction

   logic [RES_W-1:0] up_q [NUM_LIM];
   logic [RES_W-1:0] lo_q [NUM_LIM];
   logic [RES_W-1:0] hy_q [NUM_LIM];

   genvar g;
   generate
      for (g = 0; g < NUM_LIM; g++) begin : g_reg
         logic up_hit, lo_hit, hy_hit;
         assign up_hit = wr_en && (addr == ADDR_W'(g));
         assign lo_hit = wr_en && (addr == ADDR_W'(LO_BASE + g));
         assign hy_hit = wr_en && (addr == ADDR_W'(HY_BASE + g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               up_q[g] <= '1;
               lo_q[g] <= '0;
               hy_q[g] <= '0;
            end else begin
               if (up_hit) up_q[g] <= merge_byte(up_q[g], byte_sel, wdata);
               if (lo_hit) lo_q[g] <= merge_byte(lo_q[g], byte_sel, wdata);
               if (hy_hit) hy_q[g] <= merge_byte(hy_q[g], byte_sel, wdata);
            end
         end

         assign up_o[g] = up_q[g];
         assign lo_o[g] = lo_q[g];
         assign hy_o[g] = hy_q[g];
      end
   endgenerate

   assign clr_o = wr_en && (addr == ADDR_W'(CL_ADDR)) && wdata[CLR_BIT];

   logic [15:0] rd_word;
   always_comb begin
      rd_word = '0;
      for (int i = 0; i < NUM_LIM; i++) begin
         if (addr == ADDR_W'(i))           rd_word = 16'(up_q[i]);
         if (addr == ADDR_W'(LO_BASE + i)) rd_word = 16'(lo_q[i]);
         if (addr == ADDR_W'(HY_BASE + i)) rd_word = 16'(hy_q[i]);
      end
      if (addr == ADDR_W'(ST_ADDR)) rd_word = 16'(stat_bits);
   end

   assign rdata = byte_sel ? rd_word[7:0] : rd_word[15:8];

   generate
      if (HI_BITS < 8) begin : g_pad_chk
         AST_HIBYTE_PAD: assert property (@(posedge clk) disable iff (!rst_n)
            !byte_sel |-> (rdata[7:HI_BITS] == '0)); // R9
      end
   endgenerate

endmodule

// File: rtl/win_ch_monitor.sv
module win_ch_monitor #(
   parameter int unsigned RES_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic             clr,
   input  logic [RES_W-1:0] data,
   input  logic [RES_W-1:0] up_lim,
   input  logic [RES_W-1:0] lo_lim,
   input  logic [RES_W-1:0] hyst,
   output logic             hi_nxt,
   output logic             lo_nxt,
   output logic             hi_q,
   output logic             lo_q
);
   logic [RES_W-1:0] rel_hi;
   logic [RES_W-1:0] rel_lo;
   logic [RES_W:0]   lo_sum;

   // Saturating release points
   assign lo_sum = {1'b0, lo_lim} + {1'b0, hyst};
   assign rel_lo = lo_sum[RES_W] ? '1 : lo_sum[RES_W-1:0];
   assign rel_hi = (up_lim >= hyst) ? (up_lim - hyst) : '0;

   always_comb begin
      hi_nxt = hi_q;
      lo_nxt = lo_q;
      if (clr) begin
         hi_nxt = 1'b0;
         lo_nxt = 1'b0;
      end else if (hit) begin
         if (data > up_lim)        hi_nxt = 1'b1;
         else if (data <= rel_hi)  hi_nxt = 1'b0;
         if (data < lo_lim)        lo_nxt = 1'b1;
         else if (data >= rel_lo)  lo_nxt = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= 1'b0;
         lo_q <= 1'b0;
      end else begin
         hi_q <= hi_nxt;
         lo_q <= lo_nxt;
      end
   end

   AST_UPPER_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !clr && data > up_lim) |=> hi_q); // R3
   AST_LOWER_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !clr && data < lo_lim) |=> lo_q); // R3
   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!hi_q && !lo_q)); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !clr) |=> ($stable(hi_q) && $stable(lo_q))); // R11

endmodule

// File: rtl/win_alert_top.sv
module win_alert_top
   import win_alert_pkg::*;
#(
   parameter int unsigned RES_W   = 12,
   parameter int unsigned CH_W    = 3,
   parameter int unsigned NUM_LIM = 4,
   parameter int unsigned ADDR_W  = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  res_valid,
   input  logic [CH_W-1:0]       res_ch,
   input  logic [RES_W-1:0]      res_data,
   input  logic                  reg_wr,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic                  reg_byte_sel,
   input  logic [7:0]            reg_wdata,
   output logic [7:0]            reg_rdata,
   output logic                  out_valid,
   output logic [RES_W+CH_W:0]   out_word,
   output logic                  alert_o
);
   localparam int unsigned NUM_CH = 1 << CH_W;
   localparam int unsigned OUT_W  = RES_W + CH_W + 1;

   generate
      if (NUM_LIM > NUM_CH || NUM_LIM == 0) begin : g_bad_lim
         $error("win_alert_top: NUM_LIM must be 1..NUM_CH");
      end
   endgenerate

   logic [RES_W-1:0]     up_lim [NUM_LIM];
   logic [RES_W-1:0]     lo_lim [NUM_LIM];
   logic [RES_W-1:0]     hyst   [NUM_LIM];
   logic                 clr;
   logic [NUM_LIM-1:0]   hi_now, lo_now, hi_nxt, lo_nxt;
   logic                 any_nxt;

   win_lim_regs #(
      .NUM_LIM (NUM_LIM),
      .RES_W   (RES_W),
      .ADDR_W  (ADDR_W)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr),
      .addr      (reg_addr),
      .byte_sel  (reg_byte_sel),
      .wdata     (reg_wdata),
      .stat_bits ({lo_now, hi_now}),
      .rdata     (reg_rdata),
      .up_o      (up_lim),
      .lo_o      (lo_lim),
      .hy_o      (hyst),
      .clr_o     (clr)
   );

   genvar g;
   generate
      for (g = 0; g < NUM_LIM; g++) begin : g_mon
         logic sel;
         assign sel = res_valid && (res_ch == CH_W'(g));
         win_ch_monitor #(.RES_W(RES_W)) i_mon (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (sel),
            .clr    (clr),
            .data   (res_data),
            .up_lim (up_lim[g]),
            .lo_lim (lo_lim[g]),
            .hyst   (hyst[g]),
            .hi_nxt (hi_nxt[g]),
            .lo_nxt (lo_nxt[g]),
            .hi_q   (hi_now[g]),
            .lo_q   (lo_now[g])
         );
      end
   endgenerate

   assign any_nxt = |{hi_nxt, lo_nxt};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alert_o   <= 1'b0;
         out_valid <= 1'b0;
         out_word  <= '0;
      end else begin
         alert_o   <= any_nxt;
         out_valid <= res_valid;
         if (res_valid) out_word <= {any_nxt, res_ch, res_data};
      end
   end

   AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_word[OUT_W-1] == alert_o)); // R7
   AST_WORD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> (out_valid && out_word[OUT_W-2:RES_W] == $past(res_ch))); // R7
   AST_NOLIM_CH: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_ch >= CH_W'(NUM_LIM) && !clr) |=> $stable(alert_o)); // R2
   AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!res_valid && !clr) |=> ($stable(hi_now) && $stable(lo_now))); // R11

endmodule

// File: tb/test_win_alert_top.sv
module test_win_alert_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        res_valid = 1'b0;
   logic [2:0]  res_ch = '0;
   logic [11:0] res_data = '0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic        reg_byte_sel = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        out_valid;
   logic [15:0] out_word;
   logic        alert_o;

   always #5 clk = ~clk;

   win_alert_top i_win_alert_top (
      .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ch(res_ch),
      .res_data(res_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_byte_sel(reg_byte_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .out_valid(out_valid), .out_word(out_word), .alert_o(alert_o)
   );

   int total = 0;
   int bad = 0;
   bit done = 0;

   // Bench model of the window state
   logic [11:0] m_up [4];
   logic [11:0] m_lo [4];
   logic [11:0] m_hy [4];
   logic        m_hs [4];
   logic        m_ls [4];

   typedef struct { logic [15:0] w; logic a; string tag; } exp_t;
   exp_t q[$];

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic m_any();
      logic a = 1'b0;
      for (int i = 0; i < 4; i++) a = a | m_hs[i] | m_ls[i];
      return a;
   endfunction

   function automatic logic [7:0] m_stat();
      logic [7:0] s = '0;
      for (int i = 0; i < 4; i++) begin
         s[i]   = m_hs[i];
         s[4+i] = m_ls[i];
      end
      return s;
   endfunction

   // Requirement-level update: R3 set, R4 release, R5 hold, R6 saturation
   task automatic m_apply(input logic [2:0] ch, input logic [11:0] d);
      int c;
      int rh, rl;
      if (ch < 4) begin
         c  = int'(ch);
         rh = int'(m_up[c]) - int'(m_hy[c]);
         if (rh < 0) rh = 0;
         rl = int'(m_lo[c]) + int'(m_hy[c]);
         if (rl > 4095) rl = 4095;
         if (d > m_up[c]) m_hs[c] = 1'b1;
         else if (int'(d) <= rh) m_hs[c] = 1'b0;
         if (d < m_lo[c]) m_ls[c] = 1'b1;
         else if (int'(d) >= rl) m_ls[c] = 1'b0;
      end
   endtask

   // Driver: push the expected item, then strobe one result
   task automatic send(input logic [2:0] ch, input logic [11:0] d, input string tag);
      exp_t e;
      m_apply(ch, d);
      e.w = {m_any(), ch, d};
      e.a = m_any();
      e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      res_valid = 1'b1; res_ch = ch; res_data = d;
      @(negedge clk);
      res_valid = 1'b0;
   endtask

   // Monitor: compare words as they emerge
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (q.size() == 0) begin
            chk("R7 unexpected word", 16'(out_valid), 16'h0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, out_word, e.w);
            chk({e.tag, " alert"}, 16'(alert_o), 16'(e.a));
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic bs, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_byte_sel = bs; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic bs, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a; reg_byte_sel = bs;
      #1 v = reg_rdata;
   endtask

   task automatic set12(input logic [3:0] a, input logic [11:0] v);
      wr(a, 1'b0, {4'hF, v[11:8]});   // top nibble must be ignored
      wr(a, 1'b1, v[7:0]);
   endtask

   task automatic clear_all();
      wr(4'd13, 1'b1, 8'h01);
      for (int i = 0; i < 4; i++) begin m_hs[i] = 1'b0; m_ls[i] = 1'b0; end
   endtask

   task automatic chk_stat(input string tag);
      logic [7:0] v;
      rd(4'd12, 1'b1, v);
      chk(tag, 16'(v), 16'(m_stat()));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      for (int i = 0; i < 4; i++) begin
         m_up[i] = 12'hFFF; m_lo[i] = '0; m_hy[i] = '0; m_hs[i] = 0; m_ls[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      chk("R1 out_valid", 16'(out_valid), 16'h0);
      chk("R1 alert_o", 16'(alert_o), 16'h0);
      rd(4'd0, 1'b0, v); chk("R1 upper0 hi byte", 16'(v), 16'h0F);
      rd(4'd3, 1'b1, v); chk("R1 upper3 lo byte", 16'(v), 16'hFF);
      rd(4'd5, 1'b1, v); chk("R1 lower1 lo byte", 16'(v), 16'h00);
      rd(4'd9, 1'b0, v); chk("R1 hyst1 hi byte", 16'(v), 16'h00);
      chk_stat("R1 status");

      // Default window: nothing alerts
      send(3'd0, 12'hFFF, "R3 default window top");
      send(3'd1, 12'h000, "R3 default window bottom");

      // R9 register writes and byte lanes
      set12(4'd0, 12'h800); m_up[0] = 12'h800;
      set12(4'd8, 12'h010); m_hy[0] = 12'h010;
      set12(4'd5, 12'h100); m_lo[1] = 12'h100;
      set12(4'd9, 12'h020); m_hy[1] = 12'h020;
      rd(4'd0, 1'b0, v); chk("R9 upper0 hi byte padded", 16'(v), 16'h08);
      rd(4'd0, 1'b1, v); chk("R9 upper0 lo byte", 16'(v), 16'h00);
      wr(4'd9, 1'b1, 8'h21); m_hy[1] = 12'h021;
      rd(4'd9, 1'b0, v); chk("R9 lo write keeps hi byte", 16'(v), 16'h00);
      rd(4'd9, 1'b1, v); chk("R9 hyst1 lo byte", 16'(v), 16'h21);
      wr(4'd9, 1'b1, 8'h20); m_hy[1] = 12'h020;

      // R3 boundary and set, R7 flag
      send(3'd0, 12'h800, "R3 equal to upper no alert");
      send(3'd0, 12'h801, "R3 upper set");
      chk_stat("R10 status upper ch0");
      send(3'd5, 12'h123, "R7 flag from other channel R2");
      send(3'd0, 12'h7F1, "R5 band hold upper");
      send(3'd0, 12'h7F0, "R4 upper release");
      chk_stat("R4 status after release");

      // Lower side
      send(3'd1, 12'h100, "R3 equal to lower no alert");
      send(3'd1, 12'h0FF, "R3 lower set");
      chk_stat("R10 status lower ch1");
      wr(4'd12, 1'b1, 8'h00);
      chk_stat("R10 status write ignored");
      send(3'd1, 12'h11F, "R5 band hold lower");
      send(3'd1, 12'h120, "R4 lower release");

      // R6 saturation at both ends
      set12(4'd2, 12'h005); m_up[2] = 12'h005;
      set12(4'd10, 12'hFFF); m_hy[2] = 12'hFFF;
      send(3'd2, 12'h006, "R6 upper set small limit");
      send(3'd2, 12'h001, "R6 no wrap hold");
      send(3'd2, 12'h000, "R6 saturated release at 0");
      set12(4'd7, 12'hFF0); m_lo[3] = 12'hFF0;
      set12(4'd11, 12'h100); m_hy[3] = 12'h100;
      send(3'd3, 12'hFEF, "R6 lower set near top");
      send(3'd3, 12'hFFE, "R6 no wrap hold lower");
      send(3'd3, 12'hFFF, "R6 saturated release at full scale");

      // R2 window-less channels with extreme values
      send(3'd4, 12'h000, "R2 ch4 zero");
      send(3'd7, 12'hFFF, "R2 ch7 full");
      chk_stat("R2 status untouched");

      // R8 clear command
      send(3'd0, 12'hFFF, "R3 upper set again");
      send(3'd1, 12'h000, "R3 lower set again");
      clear_all();
      chk("R8 alert cleared", 16'(alert_o), 16'h0);
      chk_stat("R8 status cleared");

      // R8 clear colliding with a strobe
      begin
         exp_t e;
         e.w = {1'b0, 3'd0, 12'hFFF}; e.a = 1'b0; e.tag = "R8 clear beats strobe";
         q.push_back(e);
         @(negedge clk);
         res_valid = 1'b1; res_ch = 3'd0; res_data = 12'hFFF;
         reg_wr = 1'b1; reg_addr = 4'd13; reg_byte_sel = 1'b1; reg_wdata = 8'h01;
         @(negedge clk);
         res_valid = 1'b0; reg_wr = 1'b0;
      end
      chk_stat("R8 status after collision");

      // R11 idle holds and latency
      send(3'd1, 12'h050, "R11 alert one clock after strobe");
      repeat (5) @(negedge clk);
      chk("R11 idle alert hold", 16'(alert_o), 16'(m_any()));
      chk("R11 idle no word", 16'(out_valid), 16'h0);
      chk_stat("R11 idle status hold");

      repeat (3) @(negedge clk);
      chk("R7 all words seen", 16'(q.size()), 16'h0);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule